// File: doc/BRIEF.md
# Microframe index with gated periodic enable

This block keeps the 14-bit microframe index of a USB host controller and decides, at frame boundaries only, whether the periodic schedule is active. The low three index bits count microframes inside a frame and the upper eleven bits hold the frame number. The index advances on a one-cycle microframe tick while the controller runs. The start-of-frame value is taken from the frame field.

Software writes a periodic-enable command bit and polls a read-only status bit. The status bit takes the command only on the edge where the microframe field wraps from 7 to 0. As a result, turning the schedule on or off always happens on a frame boundary. Software must not write the command while command and status disagree. Such a write is dropped and raises a sticky error flag.

While the accepted state is enabled, the block does two things. It forms the frame-list entry address from a 4 KB-aligned base register and the frame number. It also pulses a fetch request once at the start of every frame. While disabled, it drives no request and an all-zero address.

Top module: `mfidx_periodic_gate`

## Requirements
- R1: While rst_ni is low, and on its release, frame_idx_o, cmd_o, sts_o, err_o and fetch_req_o are 0 and fetch_addr_o is 0.
- R2: On a clock edge with run_i and tick_i both high, frame_idx_o increases by one. On any other edge it holds.
- R3: frame_idx_o wraps from 16383 to 0. Bits [2:0] are the microframe field and bits [13:3] are the frame field. The frame field steps only when an advance takes the microframe field from 7 to 0.
- R4: sof_val_o always shows the frame field, so it changes only on an advancing edge with the microframe field at 7.
- R5: sts_o changes only on an advancing edge with the microframe field at 7. On that edge it loads the value cmd_o held before the edge. run_i low or tick_i low defers this.
- R6: A write (cmd_we_i high) while cmd_o equals sts_o loads cmd_wdata_i into cmd_o on that edge.
- R7: A write while cmd_o differs from sts_o leaves cmd_o unchanged and sets err_o. err_o then stays 1 until reset.
- R8: fetch_req_o is high for exactly the one cycle after an edge on which sts_o becomes or stays 1 at a frame boundary. It is never high while sts_o is 0.
- R9: While sts_o is 1, fetch_addr_o equals {base[31:12], frame_idx_o[12:3], 2'b00}. While sts_o is 0 it is 0. A base write (base_we_i) stores base_wdata_i[31:12], and bits [11:0] are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| run_i | input | 1 | Controller running; ticks are ignored when low |
| tick_i | input | 1 | One-cycle microframe tick |
| cmd_we_i | input | 1 | Write strobe for the periodic-enable command |
| cmd_wdata_i | input | 1 | Command write value |
| base_we_i | input | 1 | Write strobe for the frame-list base |
| base_wdata_i | input | 32 | Frame-list base write value |
| cmd_o | output | 1 | Periodic-enable command bit |
| sts_o | output | 1 | Accepted periodic state |
| err_o | output | 1 | Sticky flag for a dropped command write |
| frame_idx_o | output | 14 | Microframe index |
| sof_val_o | output | 11 | Start-of-frame frame value |
| fetch_req_o | output | 1 | One-cycle frame-list fetch request |
| fetch_addr_o | output | 32 | Frame-list entry address |

## Verification
Each internal register has its own visible symptom at the ports:
- An index that skips or stalls wrongly shows on frame_idx_o one cycle after the faulty edge. Within one frame it also shows on sof_val_o and fetch_addr_o.
- A status bit loaded at the wrong microframe, or from the wrong source, makes fetch_req_o appear or vanish at the next boundary, at most eight ticks later. It also switches fetch_addr_o between zero and a live address.
- Command or error mistakes show on cmd_o and err_o one cycle after the write.

The bench keeps a cycle-accurate arithmetic model of all of these and compares every output after every edge. It sweeps the whole index range and also covers writes landing on and around boundaries.

// File: rtl/mfidx_pkg.sv
package mfidx_pkg;
  localparam int unsigned IDX_W_DEF   = 14;
  localparam int unsigned UF_W_DEF    = 3;
  localparam int unsigned ADDR_W_DEF  = 32;
  localparam int unsigned ALIGN_W_DEF = 12;
  localparam int unsigned LIST_W_DEF  = 10;
  localparam int unsigned ENTRY_SH    = 2;  // 4-byte list entries
endpackage

// File: rtl/mfidx_counter.sv
module mfidx_counter #(
  parameter int unsigned IDX_W = mfidx_pkg::IDX_W_DEF,
  parameter int unsigned UF_W  = mfidx_pkg::UF_W_DEF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             adv_i,
  output logic [IDX_W-1:0] idx_o,
  output logic             frame_end_o
);
  logic [IDX_W-1:0] idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    idx_q <= '0;
    else if (adv_i) idx_q <= idx_q + IDX_W'(1);
  end

  assign idx_o       = idx_q;
  assign frame_end_o = adv_i && (idx_q[UF_W-1:0] == {UF_W{1'b1}});
endmodule

// File: rtl/mfidx_pen_gate.sv
module mfidx_pen_gate (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic frame_end_i,
  input  logic cmd_we_i,
  input  logic cmd_wdata_i,
  output logic cmd_o,
  output logic sts_o,
  output logic err_o,
  output logic fetch_req_o
);
  logic cmd_q, sts_q, err_q, fetch_q;
  logic agree;

  assign agree = (cmd_q == sts_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q   <= 1'b0;
      sts_q   <= 1'b0;
      err_q   <= 1'b0;
      fetch_q <= 1'b0;
    end else begin
      if (cmd_we_i) begin
        if (agree) cmd_q <= cmd_wdata_i;
        else       err_q <= 1'b1;
      end
      // command is only evaluated when microframe field rolls to 0
      if (frame_end_i) sts_q <= cmd_q;
      fetch_q <= frame_end_i & cmd_q;
    end
  end

  assign cmd_o       = cmd_q;
  assign sts_o       = sts_q;
  assign err_o       = err_q;
  assign fetch_req_o = fetch_q;
endmodule

// File: rtl/mfidx_list_addr.sv
module mfidx_list_addr #(
  parameter int unsigned ADDR_W  = mfidx_pkg::ADDR_W_DEF,
  parameter int unsigned ALIGN_W = mfidx_pkg::ALIGN_W_DEF,
  parameter int unsigned LIST_W  = mfidx_pkg::LIST_W_DEF,
  parameter int unsigned FRAME_W = mfidx_pkg::IDX_W_DEF - mfidx_pkg::UF_W_DEF
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               base_we_i,
  input  logic [ADDR_W-1:0]  base_wdata_i,
  input  logic               sts_i,
  input  logic [FRAME_W-1:0] frame_i,
  output logic [ADDR_W-1:0]  addr_o
);
  localparam int unsigned ENTRY_SH = mfidx_pkg::ENTRY_SH;
  localparam int unsigned HI_W     = ADDR_W - ALIGN_W;
  localparam int unsigned PAD_W    = ALIGN_W - LIST_W - ENTRY_SH;

  logic [HI_W-1:0]   base_q;
  logic [LIST_W-1:0] entry;
  logic [ADDR_W-1:0] raw;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        base_q <= '0;
    else if (base_we_i) base_q <= base_wdata_i[ADDR_W-1:ALIGN_W];
  end

  assign entry = frame_i[LIST_W-1:0];

  generate
    if (PAD_W > 0) begin : g_pad
      assign raw = {base_q, {PAD_W{1'b0}}, entry, {ENTRY_SH{1'b0}}};
    end else begin : g_nopad
      assign raw = {base_q, entry, {ENTRY_SH{1'b0}}};
    end
    if (FRAME_W > LIST_W) begin : g_hi_frame
      logic unused_frame_hi;
      assign unused_frame_hi = ^frame_i[FRAME_W-1:LIST_W];
    end
  endgenerate

  logic unused_base_lo;
  assign unused_base_lo = ^base_wdata_i[ALIGN_W-1:0];

  // base is not exposed while the schedule is off
  assign addr_o = sts_i ? raw : '0;
endmodule

// File: rtl/mfidx_periodic_gate.sv
module mfidx_periodic_gate #(
  parameter int unsigned IDX_W   = mfidx_pkg::IDX_W_DEF,
  parameter int unsigned UF_W    = mfidx_pkg::UF_W_DEF,
  parameter int unsigned ADDR_W  = mfidx_pkg::ADDR_W_DEF,
  parameter int unsigned ALIGN_W = mfidx_pkg::ALIGN_W_DEF,
  parameter int unsigned LIST_W  = mfidx_pkg::LIST_W_DEF
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    run_i,
  input  logic                    tick_i,
  input  logic                    cmd_we_i,
  input  logic                    cmd_wdata_i,
  input  logic                    base_we_i,
  input  logic [ADDR_W-1:0]       base_wdata_i,
  output logic                    cmd_o,
  output logic                    sts_o,
  output logic                    err_o,
  output logic [IDX_W-1:0]        frame_idx_o,
  output logic [IDX_W-UF_W-1:0]   sof_val_o,
  output logic                    fetch_req_o,
  output logic [ADDR_W-1:0]       fetch_addr_o
);
  localparam int unsigned FRAME_W = IDX_W - UF_W;

  logic             adv, frame_end;
  logic [IDX_W-1:0] idx;
  logic             sts;

  assign adv = run_i & tick_i;

  mfidx_counter #(.IDX_W(IDX_W), .UF_W(UF_W)) u_ctr (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .adv_i       (adv),
    .idx_o       (idx),
    .frame_end_o (frame_end)
  );

  mfidx_pen_gate u_gate (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .frame_end_i (frame_end),
    .cmd_we_i    (cmd_we_i),
    .cmd_wdata_i (cmd_wdata_i),
    .cmd_o       (cmd_o),
    .sts_o       (sts),
    .err_o       (err_o),
    .fetch_req_o (fetch_req_o)
  );

  mfidx_list_addr #(
    .ADDR_W(ADDR_W), .ALIGN_W(ALIGN_W), .LIST_W(LIST_W), .FRAME_W(FRAME_W)
  ) u_addr (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .base_we_i    (base_we_i),
    .base_wdata_i (base_wdata_i),
    .sts_i        (sts),
    .frame_i      (idx[IDX_W-1:UF_W]),
    .addr_o       (fetch_addr_o)
  );

  assign sts_o       = sts;
  assign frame_idx_o = idx;
  assign sof_val_o   = idx[IDX_W-1:UF_W];
endmodule

// File: rtl/mfidx_checker.sv
module mfidx_checker #(
  parameter int unsigned IDX_W  = 14,
  parameter int unsigned UF_W   = 3,
  parameter int unsigned ADDR_W = 32
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  run_i,
  input logic                  tick_i,
  input logic                  cmd_we_i,
  input logic                  cmd_o,
  input logic                  sts_o,
  input logic                  err_o,
  input logic [IDX_W-1:0]      frame_idx_o,
  input logic [IDX_W-UF_W-1:0] sof_val_o,
  input logic                  fetch_req_o,
  input logic [ADDR_W-1:0]     fetch_addr_o
);
  logic             bnd;
  logic [IDX_W-1:0] idx_nxt;

  assign bnd     = run_i && tick_i && (frame_idx_o[UF_W-1:0] == {UF_W{1'b1}});
  assign idx_nxt = frame_idx_o + IDX_W'(1);

  p_idx_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && tick_i) |=> frame_idx_o == $past(idx_nxt));
  p_idx_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(run_i && tick_i) |=> $stable(frame_idx_o));
  p_sof_stable_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bnd |=> $stable(sof_val_o));
  p_sts_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bnd |=> $stable(sts_o));
  p_sts_load_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bnd |=> sts_o == $past(cmd_o));
  p_cmd_drop_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_we_i && (cmd_o != sts_o)) |=> (cmd_o == $past(cmd_o)) && err_o);
  p_err_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o);
  p_fetch_single_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fetch_req_o |=> !fetch_req_o);
  p_fetch_ctx_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fetch_req_o |-> sts_o && (frame_idx_o[UF_W-1:0] == '0));
  p_addr_gated_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sts_o |-> fetch_addr_o == '0);
endmodule

bind mfidx_periodic_gate mfidx_checker #(
  .IDX_W(IDX_W), .UF_W(UF_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .run_i        (run_i),
  .tick_i       (tick_i),
  .cmd_we_i     (cmd_we_i),
  .cmd_o        (cmd_o),
  .sts_o        (sts_o),
  .err_o        (err_o),
  .frame_idx_o  (frame_idx_o),
  .sof_val_o    (sof_val_o),
  .fetch_req_o  (fetch_req_o),
  .fetch_addr_o (fetch_addr_o)
);

// File: tb/sim_mfidx_periodic_gate.sv
module sim_mfidx_periodic_gate;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        run_i = 1'b0, tick_i = 1'b0;
  logic        cmd_we_i = 1'b0, cmd_wdata_i = 1'b0;
  logic        base_we_i = 1'b0;
  logic [31:0] base_wdata_i = '0;
  logic        cmd_o, sts_o, err_o, fetch_req_o;
  logic [13:0] frame_idx_o;
  logic [10:0] sof_val_o;
  logic [31:0] fetch_addr_o;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  logic [13:0] m_idx;
  logic        m_cmd, m_sts, m_err, m_fetch;
  logic [19:0] m_base;

  always #2 clk_i = ~clk_i;

  mfidx_periodic_gate u0 (.*);

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_all();
    logic [31:0] ea;
    ea = m_sts ? {m_base, m_idx[12:3], 2'b00} : 32'h0;
    chk(frame_idx_o == m_idx, (m_idx[2:0] == 3'd0) ? "R3 index" : "R2 index", 32'(frame_idx_o), 32'(m_idx));
    chk(sof_val_o == m_idx[13:3], "R4 sof", 32'(sof_val_o), 32'(m_idx[13:3]));
    chk(sts_o == m_sts, "R5 status", 32'(sts_o), 32'(m_sts));
    chk(cmd_o == m_cmd, "R6 command", 32'(cmd_o), 32'(m_cmd));
    chk(err_o == m_err, "R7 error", 32'(err_o), 32'(m_err));
    chk(fetch_req_o == m_fetch, "R8 fetch", 32'(fetch_req_o), 32'(m_fetch));
    chk(fetch_addr_o == ea, "R9 address", fetch_addr_o, ea);
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0;
    run_i = 0; tick_i = 0; cmd_we_i = 0; cmd_wdata_i = 0; base_we_i = 0; base_wdata_i = '0;
    m_idx = '0; m_cmd = 0; m_sts = 0; m_err = 0; m_fetch = 0; m_base = '0;
    repeat (2) @(negedge clk_i);
    check_all();  // R1 in reset
    rst_ni = 1'b1;
    @(negedge clk_i);
    check_all();  // R1 after release
  endtask

  task automatic step(input logic rn, input logic tk, input logic cwe, input logic cwd,
                      input logic bwe, input logic [31:0] bwd);
    logic bnd;
    run_i = rn; tick_i = tk; cmd_we_i = cwe; cmd_wdata_i = cwd;
    base_we_i = bwe; base_wdata_i = bwd;
    @(posedge clk_i);
    bnd = rn && tk && (m_idx[2:0] == 3'b111);
    m_fetch = bnd && m_cmd;
    if (bnd) m_sts = m_cmd;
    else if (cwe && (m_cmd == m_sts)) m_cmd = cwd;
    if (cwe && (m_cmd != m_sts) && !bnd) m_err = 1'b1;
    if (rn && tk) m_idx = m_idx + 14'd1;
    if (bwe) m_base = bwd[31:12];
    @(negedge clk_i);
    check_all();
  endtask

  // model ordering on boundary: apply write against pre-edge values
  task automatic step_w(input logic rn, input logic tk, input logic cwe, input logic cwd);
    logic bnd, old_cmd, old_sts;
    run_i = rn; tick_i = tk; cmd_we_i = cwe; cmd_wdata_i = cwd;
    base_we_i = 0; base_wdata_i = '0;
    @(posedge clk_i);
    old_cmd = m_cmd; old_sts = m_sts;
    bnd = rn && tk && (m_idx[2:0] == 3'b111);
    if (cwe) begin
      if (old_cmd == old_sts) m_cmd = cwd;
      else m_err = 1'b1;
    end
    if (bnd) m_sts = old_cmd;
    m_fetch = bnd && old_cmd;
    if (rn && tk) m_idx = m_idx + 14'd1;
    @(negedge clk_i);
    check_all();
  endtask

  task automatic finish_run();
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    do_reset();
    // R2: run low or tick low holds the index
    for (int i = 0; i < 20; i++) step_w(1'b0, 1'b1, 1'b0, 1'b0);
    for (int i = 0; i < 30; i++) step_w(1'b1, (i % 3) == 0, 1'b0, 1'b0);
    // R9: base low bits ignored
    step(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 32'h1234_5ABC);
    while (m_idx[2:0] != 3'd3) step_w(1'b1, 1'b1, 1'b0, 1'b0);
    // R6 accepted, then R7 dropped while pending
    step_w(1'b1, 1'b0, 1'b1, 1'b1);
    step_w(1'b1, 1'b0, 1'b1, 1'b0);
    // R5: run low at microframe 7 defers the switch
    while (m_idx[2:0] != 3'd7) step_w(1'b1, 1'b1, 1'b0, 1'b0);
    for (int i = 0; i < 5; i++) step_w(1'b0, 1'b1, 1'b0, 1'b0);
    chk(sts_o == 1'b0, "R5 deferred by run low", 32'(sts_o), 32'h0);
    for (int i = 0; i < 40; i++) step_w(1'b1, 1'b1, 1'b0, 1'b0);
    chk(sts_o == 1'b1, "R5 switched on at boundary", 32'(sts_o), 32'h1);
    step_w(1'b1, 1'b0, 1'b1, 1'b0);
    for (int i = 0; i < 20; i++) step_w(1'b1, 1'b1, 1'b0, 1'b0);
    // R1: reset clears the sticky error
    do_reset();
    step(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 32'hFFFF_F7FF);
    step_w(1'b0, 1'b0, 1'b1, 1'b1);
    // R3/R8/R9: full index sweep with schedule on
    for (int i = 0; i < 16400; i++) step_w(1'b1, 1'b1, 1'b0, 1'b0);
    chk(m_idx == 14'd16, "R3 wrapped", 32'(frame_idx_o), 32'd16);
    // mixed writes around boundaries
    for (int i = 0; i < 600; i++)
      step_w(1'b1, (i % 5) != 2, (i % 11) == 0 || (i % 8) == 7, ~m_cmd);
    done = 1'b1;
    finish_run();
  end
endmodule